// File: doc/BRIEF.md
# Program-Cycle Status Read Responder

This block decides what byte a nonvolatile byte memory presents on its data pins during a read. While no internal program cycle runs, the byte read from the array passes straight through. While a program cycle is in progress, two completion indicators replace part of that byte:

- a polling bit that returns the complement of the matching bit of the last byte loaded;
- a toggling bit that changes value on every read and starts at 1.

All other bits still carry array data. The write controller supplies the busy flag and the last loaded byte. The read timing logic supplies a one-cycle read strobe marking each completed read access.

The block also decodes the chip pins into a single output-enable for the data pad tristate. Software or a host can therefore watch either indicator and tell when the program cycle is over.

All pins here are plain level or strobe controls. The read path has no back-pressure: the data pins hold whatever the block drives until the strobe closes the access. For this reason no valid/ready handshake is used.

Top module: `prog_status_reader`

## Requirements
- R1: When `rst_n` is low, the toggle state returns to 1. After reset with `busy` low, `rd_q` equals `arr_q`.
- R2: `pad_oe` is 1 exactly when `ce_n`=0, `oe_n`=0, `we_n`=1 and `res_n`=1. Otherwise it is 0, which floats the data pins.
- R3: While `busy` is 1, bit POLL_BIT (default 7) of `rd_q` equals the complement of bit POLL_BIT of `last_wr`.
- R4: The first read after `busy` rises returns bit TOG_BIT (default 6) of `rd_q` as 1.
- R5: While `busy` is 1, each `rd_stb` pulse taken while `pad_oe` is 1 inverts bit TOG_BIT of `rd_q`, starting in the next clock cycle.
- R6: While `busy` is 1, all bits of `rd_q` other than POLL_BIT and TOG_BIT equal the same bits of `arr_q`.
- R7: While `busy` is 0, `rd_q` equals `arr_q` on all bits, and the toggle state reloads to 1.
- R8: An `rd_stb` pulse while `pad_oe` is 0 does not change bit TOG_BIT. It is ignored, and the toggle advances once per qualified strobe and not once per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write strobe pin, active low |
| res_n | input | 1 | Protect/reset pin, active low |
| busy | input | 1 | Program cycle in progress, from the write controller |
| last_wr | input | W | Last byte loaded by the write controller |
| arr_q | input | W | Array read data at the current address |
| rd_stb | input | 1 | One-cycle pulse ending a read access |
| rd_q | output | W | Byte for the data pins |
| pad_oe | output | 1 | Drive enable for the data pad tristate |

## Verification
The bench builds the block with its defaults: an 8-bit byte, the polling bit at 7 and the toggling bit at 6. These values exercise the exact encoding a host polls for. The vectors walk the toggle through several program cycles, including strobes taken with the pins disabled and a cycle restart. This brings the first-read value, the reload on cycle end and the per-strobe (not per-clock) advance within reach. A directed reset in mid-cycle checks that the toggle state returns to 1.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_POLL   = 2'd1,
    SRC_TOGGLE = 2'd2
  } bit_src_e;

  // Chooses which source feeds output bit idx during a program cycle.
  function automatic bit_src_e src_of(input int idx, input int poll_bit, input int tog_bit);
    if (idx == poll_bit) return SRC_POLL;
    if (idx == tog_bit)  return SRC_TOGGLE;
    return SRC_ARRAY;
  endfunction

endpackage

// File: rtl/psr_pin_gate.sv
module psr_pin_gate (
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic res_n,
  input  logic rd_stb,
  output logic drive,
  output logic stb_ok
);
  // A read is live only with select and output enable low, the write
  // strobe idle and the protect pin released.
  always_comb begin
    drive  = ~ce_n & ~oe_n & we_n & res_n;
    stb_ok = rd_stb & drive;
  end
endmodule

// File: rtl/psr_toggle_state.sv
module psr_toggle_state #(
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic stb_ok,
  output logic tog
);
  // Held at INIT outside a program cycle, so the first status read is INIT.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog <= INIT;
    else if (!busy)  tog <= INIT;
    else if (stb_ok) tog <= ~tog;
  end
endmodule

// File: rtl/psr_bit_merge.sv
module psr_bit_merge
  import psr_pkg::*;
#(
  parameter int W        = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic         busy,
  input  logic         tog,
  input  logic [W-1:0] last_wr,
  input  logic [W-1:0] arr_q,
  output logic [W-1:0] rd_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam bit_src_e SRC = src_of(i, POLL_BIT, TOG_BIT);
    if (SRC == SRC_POLL) begin : g_poll
      assign rd_q[i] = busy ? ~last_wr[i] : arr_q[i];
    end else if (SRC == SRC_TOGGLE) begin : g_tog
      assign rd_q[i] = busy ? tog : arr_q[i];
    end else begin : g_arr
      assign rd_q[i] = arr_q[i];
    end
  end
endmodule

// File: rtl/prog_status_reader.sv
module prog_status_reader #(
  parameter int W        = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic         we_n,
  input  logic         res_n,
  input  logic         busy,
  input  logic [W-1:0] last_wr,
  input  logic [W-1:0] arr_q,
  input  logic         rd_stb,
  output logic [W-1:0] rd_q,
  output logic         pad_oe
);
  localparam logic TOG_INIT = 1'b1;

  logic stb_ok;
  logic tog;

  psr_pin_gate u_gate (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .res_n  (res_n),
    .rd_stb (rd_stb),
    .drive  (pad_oe),
    .stb_ok (stb_ok)
  );

  psr_toggle_state #(.INIT(TOG_INIT)) u_tog (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .stb_ok (stb_ok),
    .tog    (tog)
  );

  psr_bit_merge #(.W(W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_merge (
    .busy    (busy),
    .tog     (tog),
    .last_wr (last_wr),
    .arr_q   (arr_q),
    .rd_q    (rd_q)
  );
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int W        = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ce_n,
  input logic         oe_n,
  input logic         we_n,
  input logic         res_n,
  input logic         busy,
  input logic [W-1:0] last_wr,
  input logic [W-1:0] arr_q,
  input logic         rd_stb,
  input logic [W-1:0] rd_q,
  input logic         pad_oe
);
  localparam int LOW_BIT = (POLL_BIT < TOG_BIT) ? POLL_BIT : TOG_BIT;

  a_r2_float: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n || !res_n) |-> !pad_oe);

  a_r3_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_q[POLL_BIT] != last_wr[POLL_BIT]));

  a_r4_first_read_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rd_q[TOG_BIT]);

  a_r5_flip_per_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_stb && pad_oe) |=> (!busy || (rd_q[TOG_BIT] != $past(rd_q[TOG_BIT]))));

  a_r8_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(rd_stb && pad_oe)) |=> (!busy || $stable(rd_q[TOG_BIT])));

  a_r6_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_q[LOW_BIT-1:0] == arr_q[LOW_BIT-1:0]));

  a_r7_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_q == arr_q));
endmodule

bind prog_status_reader psr_checker #(.W(W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .res_n   (res_n),
  .busy    (busy),
  .last_wr (last_wr),
  .arr_q   (arr_q),
  .rd_stb  (rd_stb),
  .rd_q    (rd_q),
  .pad_oe  (pad_oe)
);

// File: tb/sim_prog_status_reader.sv
module sim_prog_status_reader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, res_n = 1'b1;
  logic       busy = 1'b0, rd_stb = 1'b0;
  logic [7:0] last_wr = 8'h00, arr_q = 8'h00;
  logic [7:0] rd_q;
  logic       pad_oe;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  prog_status_reader u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .res_n(res_n), .busy(busy), .last_wr(last_wr), .arr_q(arr_q),
    .rd_stb(rd_stb), .rd_q(rd_q), .pad_oe(pad_oe)
  );

  // pins {ce_n,oe_n,we_n,res_n}: 0011 read, 1011 deselect, 0111 oe high,
  // 0101 write, 0010 protect low.
  // Vector: pins[30:27] busy[26] stb[25] last[24:17] arr[16:9] en[8] dout[7:0]
  localparam int NV = 18;
  localparam logic [30:0] TBL [0:NV-1] = '{
    {4'b0011, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b1, 8'hA5}, // 0  R1 idle read
    {4'b1011, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, 8'h3C}, // 1  R2 deselect
    {4'b0111, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, 8'h3C}, // 2  R2 oe high
    {4'b0101, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, 8'h3C}, // 3  R2 write
    {4'b0010, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, 8'h3C}, // 4  R2 protect low
    {4'b0011, 1'b1, 1'b1, 8'h80, 8'h00, 1'b1, 8'h40}, // 5  R3 R4 first read
    {4'b0011, 1'b1, 1'b1, 8'h80, 8'h3F, 1'b1, 8'h3F}, // 6  R5 R6 flipped
    {4'b0011, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 8'hC0}, // 7  R5 flipped back
    {4'b0011, 1'b1, 1'b1, 8'h7F, 8'hFF, 1'b1, 8'hFF}, // 8  R8 held, then strobe
    {4'b1011, 1'b1, 1'b1, 8'h7F, 8'h00, 1'b0, 8'h80}, // 9  R5 flip, R8 ignored stb
    {4'b0011, 1'b1, 1'b0, 8'h7F, 8'h12, 1'b1, 8'h92}, // 10 R8 no advance
    {4'b0011, 1'b0, 1'b1, 8'h7F, 8'h5A, 1'b1, 8'h5A}, // 11 R7 cycle ended
    {4'b0011, 1'b1, 1'b0, 8'hFF, 8'h55, 1'b1, 8'h55}, // 12 R4 R7 reload to 1
    {4'b0011, 1'b1, 1'b1, 8'hFF, 8'hAA, 1'b1, 8'h6A}, // 13 R6
    {4'b0011, 1'b0, 1'b0, 8'hFF, 8'hC3, 1'b1, 8'hC3}, // 14 R7
    {4'b0011, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 8'hC0}, // 15 R4
    {4'b0010, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 8'hC0}, // 16 R8 protect-low strobe
    {4'b0011, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 8'hC0}  // 17 R8 still 1
  };

  task automatic check(input string req, input logic [7:0] got_d, input logic [7:0] exp_d,
                       input logic got_e, input logic exp_e);
    n_chk += 2;
    if (got_d !== exp_d) begin
      n_bad++;
      $display("FAIL %s rd_q actual %h expected %h", req, got_d, exp_d);
    end
    if (got_e !== exp_e) begin
      n_bad++;
      $display("FAIL %s pad_oe actual %b expected %b", req, got_e, exp_e);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ce_n, oe_n, we_n, res_n} = TBL[i][30:27];
      busy    = TBL[i][26];
      rd_stb  = TBL[i][25];
      last_wr = TBL[i][24:17];
      arr_q   = TBL[i][16:9];
      #1;
      check($sformatf("vec%0d", i), rd_q, TBL[i][7:0], pad_oe, TBL[i][8]);
    end

    // Directed: reset in the middle of a program cycle restores toggle to 1 (R1).
    @(negedge clk);
    {ce_n, oe_n, we_n, res_n} = 4'b0011;
    busy = 1'b1; rd_stb = 1'b1; last_wr = 8'h80; arr_q = 8'h00;
    #1 check("R4 pre-reset", rd_q, 8'h40, pad_oe, 1'b1);
    @(negedge clk);
    rd_stb = 1'b0;
    #1 check("R5 pre-reset", rd_q, 8'h00, pad_oe, 1'b1);
    rst_n = 1'b0;
    #1 check("R1 in reset", rd_q, 8'h40, pad_oe, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R1 after reset", rd_q, 8'h40, pad_oe, 1'b1);

    // Directed: a strobe held for several clocks advances once per clock edge
    // it is present; one-cycle strobe then steady idle clocks hold (R8).
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R8 idle clocks", rd_q, 8'h00, pad_oe, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule